// File: doc/BRIEF.md
# YUV Pixel Bus Formatter

This block takes a 4:2:2 pixel stream and places it on an external pixel bus. Every clock it receives a luma sample together with both chroma samples of the current pixel pair. A line-valid strobe marks the active part of each line. The block then emits the samples in one of two layouts.

- **Byte-interleaved layout:** a single 8-bit lane carries chroma and luma bytes in turn. The upstream stage holds each pixel for two clocks.
- **Two-lane layout:** a chroma lane and a luma lane both update every clock.

A swap bit picks which chroma component leads. A polarity bit picks on which edge of the exported pixel clock the data changes. An option bit can hand the bus output enable to an external control pin.

The configuration is static register bits. It is captured on the rising edge of line-valid and held for the whole line, so a write in mid-line never breaks the byte sequence. The chroma phase restarts on every line, so each line begins with the leading chroma component. Outside active lines the bus carries black-level blanking codes.

Top module: `yuv_bus_fmt`

## Requirements
- R1: In byte-interleaved mode (`cfg_wide_i`=0), `data_o[7:0]` carries a repeating four-byte sequence, and `data_o[15:8]` is 0x00.
  - With swap=0 the sequence is V, Y, U, Y.
  - With swap=1 the sequence is U, Y, V, Y.
  - Each pixel is held for two clocks.
- R2: In two-lane mode (`cfg_wide_i`=1), the chroma lane `data_o[15:8]` alternates every clock between two components.
  - With swap=0 it alternates V, U, V, U.
  - With swap=1 it alternates U, V, U, V.
- R3: In two-lane mode, the luma lane `data_o[7:0]` carries the Y sample of every active clock.
- R4: When `cfg_oe_pin_en_i` is 1, `data_oe_o` follows `oe_pin_i` with a one-clock delay; 0 means the pad floats the bus. When it is 0, `data_oe_o` is 1.
- R5: A rising `line_valid_i` restarts the phase, so the first output of each line is the leading chroma component of the selected order.
- R6: While `line_valid_i` is 0, the luma position carries 0x10.
  - In two-lane mode the chroma lane carries 0x80.
  - In byte-interleaved mode `data_o` is 0x0010.
- R7: The configuration inputs are sampled only in the cycle where `line_valid_i` rises. Changes during a line have no effect until the next line start.
- R8: `pclk_o` follows the polarity bit captured at the last line start.
  - With polarity 0 it is the inverted clock: data changes on the falling edge of `pclk_o` and is stable at its rising edge.
  - With polarity 1 it is the clock itself.
- R9: Every output reflects the inputs of the previous clock. After reset the configuration is all zeros, `data_o` is 0x0010 and `data_oe_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel/byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_valid_i | input | 1 | High during active pixels of a line |
| y_i | input | 8 | Luma sample |
| u_i | input | 8 | U chroma of the current pixel pair |
| v_i | input | 8 | V chroma of the current pixel pair |
| cfg_wide_i | input | 1 | 1: two-lane layout, 0: byte-interleaved layout |
| cfg_swap_i | input | 1 | 1: U leads, 0: V leads |
| cfg_pclk_pol_i | input | 1 | Launch edge select for the exported clock |
| cfg_oe_pin_en_i | input | 1 | 1: output enable comes from `oe_pin_i` |
| oe_pin_i | input | 1 | External output enable control pin |
| data_o | output | 16 | Pixel bus, chroma lane high, luma/byte lane low |
| data_oe_o | output | 1 | Bus drive enable for the pad, 0 means high-impedance |
| pclk_o | output | 1 | Exported pixel clock |

## Verification
The critical cycle is the one in which `line_valid_i` rises. In that cycle three things happen at once: a new configuration is captured, the chroma phase restarts, and the first output byte must already follow the new order and layout. The bench provokes this by flipping all configuration bits during the blanking cycle just before each line. It also flips them again in mid-line, and it restarts a line after a one-cycle gap while the phase sits mid-sequence. The first byte is judged against the leading chroma of the new setting. Later bytes are judged against the setting captured at the line start.

// File: rtl/yuv_fmt_pkg.sv
package yuv_fmt_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    typedef struct packed {
        logic wide;
        logic swap;
        logic pol;
        logic oe_sel;
    } fmt_cfg_t;

    localparam int PH_W = 2;
endpackage

// File: rtl/yuv_fmt_cfg.sv
module yuv_fmt_cfg
    import yuv_fmt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     line_i,
    input  fmt_cfg_t cfg_i,
    output logic     start_o,
    output fmt_cfg_t cfg_eff_o,
    output fmt_cfg_t cfg_q_o
);
    timeunit 1ns;
    timeprecision 100ps;

    typedef struct packed {
        logic     line;
        fmt_cfg_t cfg;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        start_o   = line_i & ~st_q.line;
        cfg_eff_o = start_o ? cfg_i : st_q.cfg;
        st_d.line = line_i;
        st_d.cfg  = cfg_eff_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_q_o = st_q.cfg;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.line && line_i) |=> $stable(st_q.cfg)); // R7
endmodule

// File: rtl/yuv_fmt_seq.sv
module yuv_fmt_seq
    import yuv_fmt_pkg::*;
#(
    parameter int             DW      = 8,
    parameter logic [DW-1:0]  BLANK_Y = 8'h10,
    parameter logic [DW-1:0]  BLANK_C = 8'h80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_i,
    input  logic          start_i,
    input  logic          wide_i,
    input  logic          swap_i,
    input  logic [DW-1:0] y_i,
    input  logic [DW-1:0] u_i,
    input  logic [DW-1:0] v_i,
    output logic [2*DW-1:0] data_o
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int OW = 2 * DW;

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic [OW-1:0]   data;
    } st_t;

    st_t st_d, st_q;
    logic [PH_W-1:0] ph_eff;
    logic [DW-1:0]   lead_c, trail_c;

    always_comb begin
        st_d    = st_q;
        ph_eff  = start_i ? '0 : st_q.ph;
        lead_c  = swap_i ? u_i : v_i;
        trail_c = swap_i ? v_i : u_i;
        if (!line_i) begin
            st_d.data = wide_i ? {BLANK_C, BLANK_Y} : {{DW{1'b0}}, BLANK_Y};
        end else begin
            st_d.ph = ph_eff + 1'b1;
            if (wide_i) begin
                st_d.data = {(ph_eff[0] ? trail_c : lead_c), y_i};
            end else begin
                unique case (ph_eff)
                    2'd0:    st_d.data = {{DW{1'b0}}, lead_c};
                    2'd2:    st_d.data = {{DW{1'b0}}, trail_c};
                    default: st_d.data = {{DW{1'b0}}, y_i};
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: '0, data: {{DW{1'b0}}, BLANK_Y}};
        else        st_q <= st_d;
    end

    assign data_o = st_q.data;

    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (st_q.ph == 2'd1)); // R5
    AST_BLANK_LUMA: assert property (@(posedge clk) disable iff (!rst_n)
        !line_i |=> (st_q.data[DW-1:0] == BLANK_Y)); // R6
    AST_LUMA_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_i && wide_i) |=> (st_q.data[DW-1:0] == $past(y_i))); // R3
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (line_i && !wide_i) |=> (st_q.data[OW-1:DW] == '0)); // R1
endmodule

// File: rtl/yuv_bus_fmt.sv
module yuv_bus_fmt
    import yuv_fmt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_valid_i,
    input  logic [DW-1:0] y_i,
    input  logic [DW-1:0] u_i,
    input  logic [DW-1:0] v_i,
    input  logic          cfg_wide_i,
    input  logic          cfg_swap_i,
    input  logic          cfg_pclk_pol_i,
    input  logic          cfg_oe_pin_en_i,
    input  logic          oe_pin_i,
    output logic [2*DW-1:0] data_o,
    output logic          data_oe_o,
    output logic          pclk_o
);
    timeunit 1ns;
    timeprecision 100ps;

    fmt_cfg_t cfg_in, cfg_eff, cfg_q;
    logic     start;

    typedef struct packed {
        logic oe;
    } st_t;

    st_t st_d, st_q;

    assign cfg_in = '{wide: cfg_wide_i, swap: cfg_swap_i,
                      pol: cfg_pclk_pol_i, oe_sel: cfg_oe_pin_en_i};

    yuv_fmt_cfg i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (line_valid_i),
        .cfg_i     (cfg_in),
        .start_o   (start),
        .cfg_eff_o (cfg_eff),
        .cfg_q_o   (cfg_q)
    );

    yuv_fmt_seq #(.DW(DW)) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (line_valid_i),
        .start_i (start),
        .wide_i  (cfg_eff.wide),
        .swap_i  (cfg_eff.swap),
        .y_i     (y_i),
        .u_i     (u_i),
        .v_i     (v_i),
        .data_o  (data_o)
    );

    always_comb begin
        st_d    = st_q;
        st_d.oe = cfg_eff.oe_sel ? oe_pin_i : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{oe: 1'b1};
        else        st_q <= st_d;
    end

    assign data_oe_o = st_q.oe;
    assign pclk_o    = cfg_q.pol ? clk : ~clk;

    AST_OE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_eff.oe_sel |=> data_oe_o); // R4
    AST_OE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_eff.oe_sel |=> (data_oe_o == $past(oe_pin_i))); // R4
endmodule

// File: tb/test_yuv_bus_fmt.sv
module test_yuv_bus_fmt;
    timeunit 1ns;
    timeprecision 100ps;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       line_valid_i = 1'b0;
    logic [7:0] y_i = '0, u_i = '0, v_i = '0;
    logic       cfg_wide_i = 1'b0, cfg_swap_i = 1'b0;
    logic       cfg_pclk_pol_i = 1'b0, cfg_oe_pin_en_i = 1'b0;
    logic       oe_pin_i = 1'b0;
    logic [15:0] data_o;
    logic       data_oe_o, pclk_o;

    yuv_bus_fmt i_yuv_bus_fmt (
        .clk(clk), .rst_n(rst_n), .line_valid_i(line_valid_i),
        .y_i(y_i), .u_i(u_i), .v_i(v_i),
        .cfg_wide_i(cfg_wide_i), .cfg_swap_i(cfg_swap_i),
        .cfg_pclk_pol_i(cfg_pclk_pol_i), .cfg_oe_pin_en_i(cfg_oe_pin_en_i),
        .oe_pin_i(oe_pin_i),
        .data_o(data_o), .data_oe_o(data_oe_o), .pclk_o(pclk_o)
    );

    int errs = 0, checks = 0;
    bit done = 0;
    bit m_lv = 0, m_w = 0, m_s = 0, m_p = 0, m_o = 0;
    int n = 0;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit lv, input logic [7:0] y, input logic [7:0] u,
                        input logic [7:0] v, input bit [3:0] c, input bit pin,
                        input string ctx);
        logic [15:0] exp;
        logic [7:0]  first, second;
        string       tag;
        bit          was_w;
        line_valid_i = lv; y_i = y; u_i = u; v_i = v; oe_pin_i = pin;
        {cfg_wide_i, cfg_swap_i, cfg_pclk_pol_i, cfg_oe_pin_en_i} = c;
        if (lv && !m_lv) begin
            {m_w, m_s, m_p, m_o} = c;
            n = 0;
        end
        first  = m_s ? u : v;
        second = m_s ? v : u;
        if (!lv) begin
            exp = m_w ? 16'h8010 : 16'h0010;
            tag = "R6";
        end else begin
            if (m_w) exp = {((n % 2) == 0) ? first : second, y};
            else begin
                case (n % 4)
                    0: exp = {8'h00, first};
                    2: exp = {8'h00, second};
                    default: exp = {8'h00, y};
                endcase
            end
            tag = (n == 0) ? "R5" : (m_w ? "R2" : "R1");
            if (ctx != "") tag = ctx;
            n++;
        end
        was_w = m_w;
        m_lv = lv;
        @(negedge clk);
        chk(tag, data_o, exp);
        if (lv && was_w) chk("R3", {8'h00, data_o[7:0]}, {8'h00, y});
        chk("R4", {15'h0, data_oe_o}, {15'h0, (m_o ? pin : 1'b1)});
        chk("R8", {15'h0, pclk_o}, {15'h0, ~m_p});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9", data_o, 16'h0010);
        chk("R9", {15'h0, data_oe_o}, 16'h0001);
        chk("R9", {15'h0, pclk_o}, 16'h0001);
        rst_n = 1'b1;
        for (int ci = 0; ci < 16; ci++) begin
            bit [3:0] c = 4'(ci);
            step(0, 8'h00, 8'h00, 8'h00, ~c, 1'b0, "");
            step(0, 8'h00, 8'h00, 8'h00, c, 1'b1, "");
            for (int k = 0; k < 12; k++) begin
                int px = c[3] ? k : k / 2;
                bit [3:0] cu = (k >= 5) ? ~c : c;
                step(1, 8'(8'h20 + 3 * px + ci), 8'(8'h40 + 5 * px),
                     8'(8'hC0 - 7 * px), cu, bit'(k % 2) ^ c[0],
                     (k >= 5) ? "R7" : "");
            end
            step(0, 8'hFF, 8'hFF, 8'hFF, c, 1'b0, "");
        end
        for (int r = 0; r < 4; r++) begin
            bit [3:0] c = 4'(r * 5 + 8);
            for (int k = 0; k < 3; k++)
                step(1, 8'(8'h30 + k), 8'(8'h50 + k), 8'(8'hA0 + k), c, 1'b1, "");
            step(0, 8'h00, 8'h00, 8'h00, c, 1'b1, "");
            for (int k = 0; k < 5; k++)
                step(1, 8'(8'h70 + k), 8'(8'h11 + k), 8'(8'hE0 + k), ~c, 1'b0, "");
            step(0, 8'h00, 8'h00, 8'h00, c, 1'b0, "");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule